// File: doc/BRIEF.md
# Buffer Descriptor Ring Sequencer

This block owns a table of 128 buffer descriptors for a DMA Ethernet MAC and divides it into two rings at a programmable split point. Indices below the split form the transmit ring. Indices from the split up to 127 form the receive ring. Each descriptor has two 32-bit words. Word 0 holds the flags, with the length in its upper half. Word 1 holds the buffer pointer. The block tracks the current transmit and receive index. It tells the transmit datapath when a frame may go out and tells the receive datapath when a frame may be accepted. When a datapath reports completion, the block updates the descriptor, moves the index on, and latches interrupt requests.

Each ring is sequenced by a two-state machine. On the transmit side, `TX_IDLE` moves to `TX_ACTIVE` when the start condition holds, and `TX_ACTIVE` returns to `TX_IDLE` on `tx_done`. Once a transmit has begun it stays committed until it completes. On the receive side, `RX_IDLE` moves to `RX_OPEN` when the receive condition holds. `RX_OPEN` returns to `RX_IDLE` on `rx_done`, or earlier if the condition stops holding. A host moves data through a descriptor word port and a small configuration port. The configuration port sets the ring split, clears interrupt sources and sets the interrupt mask.

Top module: `bd_ring_seq`

## Requirements
- R1: After reset the transmit index is 0 and the receive index is 64. The split count is 64. `tx_req`, `rx_ready`, `irq` and `irq_src` are low. Every descriptor word reads 0.
- R2: The host port addresses a descriptor with `host_addr[7:1]` and a word with `host_addr[0]` (0 = flags, 1 = pointer). A write is visible on `host_rdata` from the next cycle on.
- R3: `tx_req` rises one cycle after all of the following hold at once: `tx_en` is high now and was high in the previous cycle; the split count is nonzero; flags bit 15 (ready) of the current transmit descriptor is set; and its length (flags bits 31:16) is greater than 4.
- R4: On `tx_done` in `TX_ACTIVE`, the descriptor's flags keep only the bits outside 15, 8 and 7:0. The index becomes 0 if flags bit 13 (wrap) is set, or if index+1 reaches the split count. Otherwise it becomes index+1.
- R5: `rx_ready` rises one cycle after all of the following hold at once: `rx_en` is high now and was high in the previous cycle; the split count is below 128; and flags bit 15 (empty) of the current receive descriptor is set.
- R6: On `rx_done` in `RX_OPEN`, `rx_len` is written into flags bits 31:16 and bit 15 is cleared, with the other bits kept. The index becomes the split count if flags bit 13 is set or the index is 127. Otherwise it becomes index+1.
- R7: A completion whose descriptor has flags bit 14 set sets `irq_src` bit 0 (transmit) or bit 2 (receive). Configuration select 1 clears the source bits written as one. Select 2 loads the mask. `irq` is the OR of source AND mask.
- R8: A rising edge of `tx_en` sets the transmit index to 0. A rising edge of `rx_en` loads the receive index with the split count. Configuration select 0 writes the split count.
- R9: When a completion and a host write hit the same flags word in the same cycle, the completion value is stored.
- R10: A `tx_done` pulse outside `TX_ACTIVE` leaves the table and the indices unchanged. The same holds for an `rx_done` pulse outside `RX_OPEN`.
- R11: `rx_ready` drops one cycle after its condition stops holding. `tx_req` stays high until `tx_done`.
- R12: `tx_ptr` and `tx_len` show the pointer and the length of the current transmit descriptor. `rx_ptr` shows the pointer of the current receive descriptor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| host_we | input | 1 | Descriptor word write strobe |
| host_addr | input | 8 | Descriptor index in bits 7:1, word select in bit 0 |
| host_wdata | input | 32 | Descriptor write data |
| host_rdata | output | 32 | Descriptor read data for `host_addr` |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 split count, 1 source clear, 2 mask |
| cfg_wdata | input | 8 | Configuration write data |
| tx_req | output | 1 | Transmit descriptor handed to the datapath |
| tx_idx | output | 7 | Current transmit index |
| tx_ptr | output | 32 | Buffer pointer of the current transmit descriptor |
| tx_len | output | 16 | Length of the current transmit descriptor |
| tx_done | input | 1 | Single-cycle transmit completion |
| rx_ready | output | 1 | A frame may be received |
| rx_idx | output | 7 | Current receive index |
| rx_ptr | output | 32 | Buffer pointer of the current receive descriptor |
| rx_len | input | 16 | Received length, valid with `rx_done` |
| rx_done | input | 1 | Single-cycle receive completion |
| irq_src | output | 3 | Latched interrupt sources |
| irq | output | 1 | Interrupt request |

## Verification
Errors in the index registers or in the split count appear at `tx_idx`/`rx_idx` right after each completion. They also appear one cycle later as a `tx_req` or `rx_ready` that rises for the wrong descriptor, or that fails to rise. A wrong writeback mask or length merge shows up at the very next host read of the completed flags word. A state machine stuck in the wrong state shows as a request that does not drop one cycle after a completion, or as a completion on the wrong ring.

// File: rtl/bdr_pkg.sv
package bdr_pkg;

    localparam int BD_WORD_W = 32;
    localparam int BD_LEN_W  = 16;

    // flag positions inside descriptor word 0
    localparam int FLAG_OWN  = 15;  // ready (tx) / empty (rx)
    localparam int FLAG_IRQ  = 14;
    localparam int FLAG_WRAP = 13;

    // bits dropped from a transmit flags word on completion
    localparam logic [BD_WORD_W-1:0] TX_DROP_MASK = 32'h0000_81FF;

    // interrupt source layout
    localparam int SRC_W      = 3;
    localparam int SRC_TX_BIT = 0;
    localparam int SRC_RX_BIT = 2;

    // configuration selects
    localparam logic [1:0] SEL_COUNT = 2'd0;
    localparam logic [1:0] SEL_CLEAR = 2'd1;
    localparam logic [1:0] SEL_MASK  = 2'd2;

    typedef enum logic { TX_IDLE, TX_ACTIVE } tx_state_e;
    typedef enum logic { RX_IDLE, RX_OPEN   } rx_state_e;

endpackage

// File: rtl/bdr_table.sv
module bdr_table
    import bdr_pkg::*;
#(
    parameter int NUM_BD = 128,
    localparam int IDX_W = $clog2(NUM_BD)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_we,
    input  logic [IDX_W-1:0]     host_desc,
    input  logic                 host_word,
    input  logic [BD_WORD_W-1:0] host_wdata,
    output logic [BD_WORD_W-1:0] host_rdata,
    input  logic [IDX_W-1:0]     tx_idx,
    input  logic                 tx_wb_en,
    input  logic [BD_WORD_W-1:0] tx_wb_data,
    output logic [BD_WORD_W-1:0] tx_flags,
    output logic [BD_WORD_W-1:0] tx_ptr,
    input  logic [IDX_W-1:0]     rx_idx,
    input  logic                 rx_wb_en,
    input  logic [BD_WORD_W-1:0] rx_wb_data,
    output logic [BD_WORD_W-1:0] rx_flags,
    output logic [BD_WORD_W-1:0] rx_ptr
);

    logic [BD_WORD_W-1:0] flags_all [NUM_BD];
    logic [BD_WORD_W-1:0] ptr_all   [NUM_BD];

    for (genvar g = 0; g < NUM_BD; g++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
        logic [BD_WORD_W-1:0] flags_q;
        logic [BD_WORD_W-1:0] ptr_q;
        logic                 tx_hit, rx_hit, host_f_hit, host_p_hit;

        always_comb begin
            tx_hit     = tx_wb_en && (tx_idx == SLOT);
            rx_hit     = rx_wb_en && (rx_idx == SLOT);
            host_f_hit = host_we && !host_word && (host_desc == SLOT);
            host_p_hit = host_we &&  host_word && (host_desc == SLOT);
        end

        // completions win over a host write to the same flags word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags_q <= '0;
                ptr_q   <= '0;
            end else begin
                if (tx_hit)
                    flags_q <= tx_wb_data;
                else if (rx_hit)
                    flags_q <= rx_wb_data;
                else if (host_f_hit)
                    flags_q <= host_wdata;
                if (host_p_hit)
                    ptr_q <= host_wdata;
            end
        end

        assign flags_all[g] = flags_q;
        assign ptr_all[g]   = ptr_q;
    end

    always_comb begin
        host_rdata = host_word ? ptr_all[host_desc] : flags_all[host_desc];
        tx_flags   = flags_all[tx_idx];
        tx_ptr     = ptr_all[tx_idx];
        rx_flags   = flags_all[rx_idx];
        rx_ptr     = ptr_all[rx_idx];
    end

endmodule

// File: rtl/bdr_tx_fsm.sv
module bdr_tx_fsm
    import bdr_pkg::*;
#(
    parameter int NUM_BD = 128,
    localparam int IDX_W = $clog2(NUM_BD),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_en,
    input  logic [CNT_W-1:0]     ring_count,
    input  logic [BD_WORD_W-1:0] cur_flags,
    input  logic                 tx_done,
    output logic [IDX_W-1:0]     tx_idx,
    output logic                 tx_req,
    output logic                 wb_en,
    output logic [BD_WORD_W-1:0] wb_data,
    output logic                 irq_pulse
);

    tx_state_e            state_q, state_d;
    logic                 en_q;
    logic [IDX_W-1:0]     idx_q, idx_adv;
    logic [CNT_W-1:0]     idx_step;
    logic [BD_LEN_W-1:0]  cur_len;
    logic                 en_rise, en_held, start_ok;

    always_comb begin
        en_rise  = tx_en && !en_q;
        en_held  = tx_en && en_q;
        cur_len  = cur_flags[BD_WORD_W-1 -: BD_LEN_W];
        start_ok = en_held && (ring_count != '0) && cur_flags[FLAG_OWN]
                   && (cur_len > BD_LEN_W'(4));
        idx_step = {1'b0, idx_q} + CNT_W'(1);
        if (cur_flags[FLAG_WRAP] || (idx_step >= ring_count))
            idx_adv = '0;
        else
            idx_adv = idx_step[IDX_W-1:0];
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:   if (start_ok) state_d = TX_ACTIVE;
            TX_ACTIVE: if (tx_done)  state_d = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        tx_req    = (state_q == TX_ACTIVE);
        wb_en     = (state_q == TX_ACTIVE) && tx_done;
        wb_data   = cur_flags & ~TX_DROP_MASK;
        irq_pulse = wb_en && cur_flags[FLAG_IRQ];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            idx_q <= '0;
        end else begin
            en_q <= tx_en;
            if (en_rise)
                idx_q <= '0;
            else if (wb_en)
                idx_q <= idx_adv;
        end
    end

    assign tx_idx = idx_q;

endmodule

// File: rtl/bdr_rx_fsm.sv
module bdr_rx_fsm
    import bdr_pkg::*;
#(
    parameter int NUM_BD      = 128,
    parameter int RESET_COUNT = 64,
    localparam int IDX_W = $clog2(NUM_BD),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_en,
    input  logic [CNT_W-1:0]     ring_count,
    input  logic [BD_WORD_W-1:0] cur_flags,
    input  logic                 rx_done,
    input  logic [BD_LEN_W-1:0]  rx_len,
    output logic [IDX_W-1:0]     rx_idx,
    output logic                 rx_ready,
    output logic                 wb_en,
    output logic [BD_WORD_W-1:0] wb_data,
    output logic                 irq_pulse
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BD - 1);

    rx_state_e        state_q, state_d;
    logic             en_q;
    logic [IDX_W-1:0] idx_q, idx_adv;
    logic             en_rise, en_held, open_ok;

    always_comb begin
        en_rise = rx_en && !en_q;
        en_held = rx_en && en_q;
        open_ok = en_held && (ring_count < CNT_W'(NUM_BD)) && cur_flags[FLAG_OWN];
        if (cur_flags[FLAG_WRAP] || (idx_q == LAST_IDX))
            idx_adv = ring_count[IDX_W-1:0];
        else
            idx_adv = idx_q + IDX_W'(1);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (open_ok) state_d = RX_OPEN;
            RX_OPEN: if (rx_done || !open_ok) state_d = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        rx_ready  = (state_q == RX_OPEN);
        wb_en     = (state_q == RX_OPEN) && rx_done;
        wb_data   = cur_flags;
        wb_data[BD_WORD_W-1 -: BD_LEN_W] = rx_len;
        wb_data[FLAG_OWN] = 1'b0;
        irq_pulse = wb_en && cur_flags[FLAG_IRQ];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            idx_q <= IDX_W'(RESET_COUNT);
        end else begin
            en_q <= rx_en;
            if (en_rise)
                idx_q <= ring_count[IDX_W-1:0];
            else if (wb_en)
                idx_q <= idx_adv;
        end
    end

    assign rx_idx = idx_q;

endmodule

// File: rtl/bdr_ctrl_regs.sv
module bdr_ctrl_regs
    import bdr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int RESET_COUNT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             tx_irq,
    input  logic             rx_irq,
    output logic [CNT_W-1:0] ring_count,
    output logic [SRC_W-1:0] irq_src,
    output logic             irq
);

    logic [CNT_W-1:0] count_q;
    logic [SRC_W-1:0] src_q, src_d, mask_q, clr, set;

    always_comb begin
        clr = (cfg_we && cfg_sel == SEL_CLEAR) ? cfg_wdata[SRC_W-1:0] : '0;
        set = '0;
        set[SRC_TX_BIT] = tx_irq;
        set[SRC_RX_BIT] = rx_irq;
        // a new event wins over a clear of the same bit
        src_d = (src_q & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= CNT_W'(RESET_COUNT);
            src_q   <= '0;
            mask_q  <= '0;
        end else begin
            src_q <= src_d;
            if (cfg_we && cfg_sel == SEL_COUNT)
                count_q <= cfg_wdata;
            if (cfg_we && cfg_sel == SEL_MASK)
                mask_q <= cfg_wdata[SRC_W-1:0];
        end
    end

    assign ring_count = count_q;
    assign irq_src    = src_q;
    assign irq        = |(src_q & mask_q);

endmodule

// File: rtl/bd_ring_seq.sv
module bd_ring_seq
    import bdr_pkg::*;
#(
    parameter int NUM_BD      = 128,
    parameter int RESET_COUNT = 64,
    localparam int IDX_W = $clog2(NUM_BD),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_en,
    input  logic                 rx_en,
    input  logic                 host_we,
    input  logic [IDX_W:0]       host_addr,
    input  logic [BD_WORD_W-1:0] host_wdata,
    output logic [BD_WORD_W-1:0] host_rdata,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [CNT_W-1:0]     cfg_wdata,
    output logic                 tx_req,
    output logic [IDX_W-1:0]     tx_idx,
    output logic [BD_WORD_W-1:0] tx_ptr,
    output logic [BD_LEN_W-1:0]  tx_len,
    input  logic                 tx_done,
    output logic                 rx_ready,
    output logic [IDX_W-1:0]     rx_idx,
    output logic [BD_WORD_W-1:0] rx_ptr,
    input  logic [BD_LEN_W-1:0]  rx_len,
    input  logic                 rx_done,
    output logic [SRC_W-1:0]     irq_src,
    output logic                 irq
);

    logic [CNT_W-1:0]     ring_count;
    logic [BD_WORD_W-1:0] tx_flags, rx_flags, tx_wb_data, rx_wb_data;
    logic                 tx_wb_en, rx_wb_en, tx_irq, rx_irq;

    bdr_table #(.NUM_BD(NUM_BD)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_desc  (host_addr[IDX_W:1]),
        .host_word  (host_addr[0]),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .tx_idx     (tx_idx),
        .tx_wb_en   (tx_wb_en),
        .tx_wb_data (tx_wb_data),
        .tx_flags   (tx_flags),
        .tx_ptr     (tx_ptr),
        .rx_idx     (rx_idx),
        .rx_wb_en   (rx_wb_en),
        .rx_wb_data (rx_wb_data),
        .rx_flags   (rx_flags),
        .rx_ptr     (rx_ptr)
    );

    bdr_tx_fsm #(.NUM_BD(NUM_BD)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .ring_count (ring_count),
        .cur_flags  (tx_flags),
        .tx_done    (tx_done),
        .tx_idx     (tx_idx),
        .tx_req     (tx_req),
        .wb_en      (tx_wb_en),
        .wb_data    (tx_wb_data),
        .irq_pulse  (tx_irq)
    );

    bdr_rx_fsm #(.NUM_BD(NUM_BD), .RESET_COUNT(RESET_COUNT)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .ring_count (ring_count),
        .cur_flags  (rx_flags),
        .rx_done    (rx_done),
        .rx_len     (rx_len),
        .rx_idx     (rx_idx),
        .rx_ready   (rx_ready),
        .wb_en      (rx_wb_en),
        .wb_data    (rx_wb_data),
        .irq_pulse  (rx_irq)
    );

    bdr_ctrl_regs #(.CNT_W(CNT_W), .RESET_COUNT(RESET_COUNT)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .tx_irq     (tx_irq),
        .rx_irq     (rx_irq),
        .ring_count (ring_count),
        .irq_src    (irq_src),
        .irq        (irq)
    );

    assign tx_len = tx_flags[BD_WORD_W-1 -: BD_LEN_W];

endmodule

// File: rtl/bdr_checker.sv
module bdr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_en,
    input logic       rx_en,
    input logic       tx_req,
    input logic       tx_done,
    input logic       rx_ready,
    input logic       rx_done,
    input logic [2:0] irq_src,
    input logic       irq
);

    // R3 / R11: a started transmit stays requested until it completes
    assert_tx_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req && !tx_done |=> tx_req);

    // R4: completion returns the transmit machine to idle
    assert_tx_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req && tx_done |=> !tx_req);

    // R3: a request only starts when transmit was enabled
    assert_tx_start_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_req) |-> $past(tx_en));

    // R5: receive opens only while enabled
    assert_rx_open_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> $past(rx_en));

    // R6: receive completion closes the window
    assert_rx_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready && rx_done |=> !rx_ready);

    // R7: the request line needs a latched source
    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_src != 3'b000));

endmodule

bind bd_ring_seq bdr_checker u_bdr_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .rx_en    (rx_en),
    .tx_req   (tx_req),
    .tx_done  (tx_done),
    .rx_ready (rx_ready),
    .rx_done  (rx_done),
    .irq_src  (irq_src),
    .irq      (irq)
);

// File: tb/test_bd_ring_seq.sv
module test_bd_ring_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0, rx_en = 1'b0;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        tx_req, rx_ready, irq;
    logic [6:0]  tx_idx, rx_idx;
    logic [31:0] tx_ptr, rx_ptr;
    logic [15:0] tx_len;
    logic        tx_done = 1'b0, rx_done = 1'b0;
    logic [15:0] rx_len = '0;
    logic [2:0]  irq_src;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    bd_ring_seq i_bd_ring_seq (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .tx_req(tx_req), .tx_idx(tx_idx),
        .tx_ptr(tx_ptr), .tx_len(tx_len), .tx_done(tx_done),
        .rx_ready(rx_ready), .rx_idx(rx_idx), .rx_ptr(rx_ptr),
        .rx_len(rx_len), .rx_done(rx_done), .irq_src(irq_src), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic host_wr(input logic [6:0] d, input logic w, input logic [31:0] v);
        host_we = 1'b1; host_addr = {d, w}; host_wdata = v;
        tick();
        host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [6:0] d, input logic w, output logic [31:0] v);
        host_addr = {d, w};
        #0.5;
        v = host_rdata;
    endtask

    task automatic cfg_wr(input logic [1:0] s, input logic [7:0] v);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_tx();
        tx_done = 1'b1; tick(); tx_done = 1'b0;
    endtask

    task automatic pulse_rx(input logic [15:0] len);
        rx_done = 1'b1; rx_len = len; tick(); rx_done = 1'b0;
    endtask

    function automatic logic tx_startable(input logic [31:0] f);
        return f[15] && (f[31:16] > 16'd4);
    endfunction

    function automatic logic [31:0] tx_after(input logic [31:0] f);
        return f & ~32'h0000_81FF;
    endfunction

    function automatic logic [6:0] tx_next(input logic [6:0] i, input logic [31:0] f, input int cnt);
        int s = int'(i) + 1;
        if (f[13] || s >= cnt) return 7'd0;
        return 7'(s);
    endfunction

    function automatic logic [31:0] rx_after(input logic [31:0] f, input logic [15:0] len);
        return {len, f[15:0] & 16'h7FFF};
    endfunction

    function automatic logic [6:0] rx_next(input logic [6:0] i, input logic [31:0] f, input int cnt);
        if (f[13] || i == 7'd127) return 7'(cnt);
        return i + 7'd1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, f;
        logic [6:0]  ei;
        void'($urandom(32'd4242));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 tx_idx", 32'(tx_idx), 32'd0);
        chk("R1 rx_idx", 32'(rx_idx), 32'd64);
        chk("R1 tx_req", 32'(tx_req), 32'd0);
        chk("R1 rx_ready", 32'(rx_ready), 32'd0);
        chk("R1 irq", 32'({irq, irq_src}), 32'd0);
        host_rd(7'd77, 1'b1, v); chk("R1 table word", v, 32'd0);

        // R2 host port
        host_wr(7'd100, 1'b0, 32'h1234_5678);
        host_wr(7'd100, 1'b1, 32'hCAFE_F00D);
        host_rd(7'd100, 1'b0, v); chk("R2 flags word", v, 32'h1234_5678);
        host_rd(7'd100, 1'b1, v); chk("R2 pointer word", v, 32'hCAFE_F00D);

        // R3 length of 4 does not start
        host_wr(7'd0, 1'b1, 32'hA000_1000);
        host_wr(7'd0, 1'b0, 32'h0004_8000);
        tx_en = 1'b1; repeat (3) tick();
        chk("R3 len4 no start", 32'(tx_req), 32'd0);
        tx_en = 1'b0; tick();
        host_wr(7'd0, 1'b0, 32'h0005_8000); tick();
        chk("R3 disabled no start", 32'(tx_req), 32'd0);
        chk("R12 tx_len", 32'(tx_len), 32'd5);
        chk("R12 tx_ptr", tx_ptr, 32'hA000_1000);
        tx_en = 1'b1; tick(); tick();
        chk("R3 start", 32'(tx_req), 32'd1);

        // R9 collision: completion wins over host write
        host_we = 1'b1; host_addr = 8'h00; host_wdata = 32'hFFFF_FFFF; tx_done = 1'b1;
        tick();
        host_we = 1'b0; tx_done = 1'b0;
        host_rd(7'd0, 1'b0, v); chk("R9 collision", v, 32'h0005_0000);
        chk("R4 tx_idx step", 32'(tx_idx), 32'd1);

        // R10 stray tx_done
        pulse_tx(); tick();
        chk("R10 tx_idx unchanged", 32'(tx_idx), 32'd1);
        chk("R10 no request", 32'(tx_req), 32'd0);

        // R3 zero count blocks start
        cfg_wr(2'd0, 8'd0);
        host_wr(7'd1, 1'b0, 32'h000A_C000); tick();
        chk("R3 zero count", 32'(tx_req), 32'd0);
        cfg_wr(2'd0, 8'd5); tick();
        chk("R8 count write starts", 32'(tx_req), 32'd1);
        pulse_tx();
        host_rd(7'd1, 1'b0, v); chk("R4 writeback", v, 32'h000A_4000);
        chk("R4 tx_idx", 32'(tx_idx), 32'd2);
        chk("R7 src masked", 32'({irq, irq_src}), 32'b0_001);
        cfg_wr(2'd2, 8'd5);
        chk("R7 irq on mask", 32'(irq), 32'd1);
        cfg_wr(2'd1, 8'd1);
        chk("R7 w1c", 32'({irq, irq_src}), 32'd0);

        // R8 tx enable rise
        tx_en = 1'b0; tick(); tx_en = 1'b1; tick(); tick();
        chk("R8 tx_idx cleared", 32'(tx_idx), 32'd0);

        // random transmit ring traffic, count 5
        ei = 7'd0;
        for (int n = 0; n < 40; n++) begin
            f = $urandom;
            f[31:16] = 16'($urandom % 9);
            host_wr(ei, 1'b0, f); tick();
            chk("R3 random start", 32'(tx_req), 32'(tx_startable(f)));
            if (tx_startable(f)) begin
                pulse_tx();
                host_rd(ei, 1'b0, v); chk("R4 random writeback", v, tx_after(f));
                ei = tx_next(ei, f, 5);
                chk("R4 random index", 32'(tx_idx), 32'(ei));
                chk("R7 tx source", 32'({irq, irq_src}), f[14] ? 32'b1_001 : 32'd0);
                if (f[14]) cfg_wr(2'd1, 8'd1);
                tick();
            end
        end

        // R5 count at 128 blocks receive
        tx_en = 1'b0;
        cfg_wr(2'd0, 8'h80);
        rx_en = 1'b1; tick(); tick();
        chk("R8 rx load count", 32'(rx_idx), 32'd0);
        host_wr(7'd0, 1'b0, 32'h0000_8000); tick();
        chk("R5 count 128 blocks", 32'(rx_ready), 32'd0);

        // random receive ring traffic, count 5
        cfg_wr(2'd0, 8'd5);
        rx_en = 1'b0; tick(); rx_en = 1'b1; tick(); tick();
        chk("R8 rx idx reload", 32'(rx_idx), 32'd5);
        ei = 7'd5;
        for (int n = 0; n < 40; n++) begin
            logic [15:0] ln;
            f = $urandom;
            ln = 16'($urandom % 1600);
            host_wr(ei, 1'b0, f); tick();
            chk("R5 random open", 32'(rx_ready), 32'(f[15]));
            if (f[15]) begin
                pulse_rx(ln);
                host_rd(ei, 1'b0, v); chk("R6 random writeback", v, rx_after(f, ln));
                ei = rx_next(ei, f, 5);
                chk("R6 random index", 32'(rx_idx), 32'(ei));
                chk("R7 rx source", 32'({irq, irq_src}), f[14] ? 32'b1_100 : 32'd0);
                if (f[14]) cfg_wr(2'd1, 8'd4);
                tick();
            end
        end

        // R11 withdraw and R10 stray rx_done
        host_wr(rx_idx, 1'b1, 32'h0BAD_0000);
        host_wr(rx_idx, 1'b0, 32'h0000_8000); tick();
        chk("R11 open", 32'(rx_ready), 32'd1);
        chk("R12 rx_ptr", rx_ptr, 32'h0BAD_0000);
        ei = rx_idx;
        host_wr(ei, 1'b0, 32'h0000_0000); tick();
        chk("R11 withdraw", 32'(rx_ready), 32'd0);
        pulse_rx(16'd99); tick();
        chk("R10 rx_idx unchanged", 32'(rx_idx), 32'(ei));
        host_rd(ei, 1'b0, v); chk("R10 rx word unchanged", v, 32'd0);

        // R6 wrap at last index
        cfg_wr(2'd0, 8'd126);
        rx_en = 1'b0; tick(); rx_en = 1'b1; tick(); tick();
        chk("R8 rx load 126", 32'(rx_idx), 32'd126);
        host_wr(7'd126, 1'b0, 32'h0000_8000); tick();
        pulse_rx(16'd60);
        chk("R6 step to 127", 32'(rx_idx), 32'd127);
        host_wr(7'd127, 1'b0, 32'h0000_8000); tick();
        chk("R5 open 127", 32'(rx_ready), 32'd1);
        pulse_rx(16'd64);
        chk("R6 wrap at 127", 32'(rx_idx), 32'd126);
        host_rd(7'd127, 1'b0, v); chk("R6 last writeback", v, 32'h0040_0000);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule